// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects the interrupt sources of a small 8-bit CPU core and presents at most one of them at a time as a vectored request. Vector slot 0 belongs to reset and is never raised by this block. Slots 1 to 5 belong to five maskable sources. In priority order these are an external pin interrupt, a port pin-change interrupt, a timer overflow, an EEPROM-ready event and a comparator event. The three peripheral events arrive as single-cycle pulses from logic outside this block. The two pin sources are derived inside the block from the sampled levels of the I/O port.

Each maskable source has a sticky flag bit and an enable bit, and a global enable bit sits above all of them. A pending, enabled source can be offered only while the global enable is set. When that holds, the controller registers the lowest-numbered candidate, raises `irq_req` and holds the vector number until the CPU answers with a one-cycle `irq_ack`. The acknowledge takes the interrupt. Taking it clears the global enable and also clears the flag of the source that was served. The external pin can be sensed on low level, on any edge, on a falling edge or on a rising edge. In low-level mode it has no flag and only counts as pending while the pin is actually held low.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset, `irq_req` is 0, all `flags` bits are 0, `gie` is 0 and every enable bit is 0.
- R2: Flag, enable and write-data bit i belongs to vector i+1. Bit 0 is the external pin (vector 1), bit 1 is pin change (2), bit 2 is timer overflow (3), bit 3 is EEPROM ready (4) and bit 4 is comparator (5). When several enabled sources are pending, the lowest vector is offered first.
- R3: While `gie` is 0, `irq_req` never rises, whatever the flags and enable bits hold.
- R4: A source event sets its flag even while `gie` is 0. The flag stays set and is offered once `gie` is set.
- R5: A source whose enable bit is 0 is never offered, but its flag is still set by its event.
- R6: With `ext_sense` = 0 (low level), the external pin sets no flag and is pending only while the pin reads 0.
- R7: With `ext_sense` = 1, 2 or 3, flag bit 0 is set by any edge, a falling edge or a rising edge of the external pin respectively.
- R8: Flag bit 1 is set by a level change on any port pin whose bit is set in `PC_PIN_EN`. The change may come from the port driving the pin itself. Changes on other pins have no effect on it.
- R9: One transition of the external pin that is also pin-change enabled sets both flag bit 0 and flag bit 1. Vector 1 is served before vector 2.
- R10: A cycle with `irq_req` and `irq_ack` both high clears `gie` and the served flag, even if `gie_set` is high in that cycle.
- R11: A `flag_wr` cycle clears each flag whose `flag_wdata` bit is 1 and leaves the flags with a 0 bit unchanged.
- R12: Once `irq_req` is raised, it stays high with `irq_vec` unchanged until the cycle of `irq_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl | input | PIN_W | Sampled levels of the I/O port pins |
| ext_sense | input | 2 | External pin sense: 0 low level, 1 any edge, 2 falling, 3 rising |
| tov_evt | input | 1 | Timer overflow event pulse |
| eerdy_evt | input | 1 | EEPROM ready event pulse |
| cmp_evt | input | 1 | Comparator event pulse |
| flag_wr | input | 1 | Flag write strobe (write one to clear) |
| flag_wdata | input | 5 | Flag clear bits |
| mask_wr | input | 1 | Enable bits write strobe |
| mask_wdata | input | 5 | New enable bits |
| gie_set | input | 1 | Set the global enable |
| gie_clr | input | 1 | Clear the global enable |
| irq_ack | input | 1 | CPU takes the offered interrupt |
| irq_req | output | 1 | Interrupt offered to the CPU |
| irq_vec | output | 3 | Vector number of the offered interrupt |
| flags | output | 5 | Current flag bits |
| gie | output | 1 | Current global enable |

## Verification
The bench builds the block with its defaults: a six-pin port, the external interrupt on pin 1, and pin-change sensing on pins 0 to 4 but not on pin 5. That layout puts an excluded pin within reach, which shows that pin-change sensing ignores it. It also puts a pin that feeds both the external interrupt and pin change within reach, so the double flag and its service order can be exercised. All four sense modes are driven on that shared pin. Flags are stacked while the global enable is off to expose the service order, and an acknowledge is issued in the same cycle as a global-enable set.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam int unsigned IRQ_N = 5;
   localparam int unsigned VEC_W = $clog2(IRQ_N + 1);

   localparam int unsigned SRC_EXT   = 0;
   localparam int unsigned SRC_PCHG  = 1;
   localparam int unsigned SRC_TOV   = 2;
   localparam int unsigned SRC_EERDY = 3;
   localparam int unsigned SRC_CMP   = 4;

   typedef enum logic [1:0] {
      SENSE_LOW  = 2'd0,
      SENSE_ANY  = 2'd1,
      SENSE_FALL = 2'd2,
      SENSE_RISE = 2'd3
   } sense_e;

   typedef enum logic {
      TK_IDLE  = 1'b0,
      TK_OFFER = 1'b1
   } take_st_e;
endpackage

// File: rtl/intc_sense.sv
module intc_sense import intc_pkg::*; #(
   parameter int unsigned PIN_W = 6,
   parameter int unsigned EXT_PIN = 1,
   parameter logic [PIN_W-1:0] PC_PIN_EN = {1'b0, {(PIN_W-1){1'b1}}}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PIN_W-1:0] pin_lvl,
   input  logic [1:0]       ext_sense,
   output logic             ext_evt,
   output logic             ext_lvl,
   output logic             pchg_evt
);
   generate
      if (EXT_PIN >= PIN_W) begin : g_bad_ext
         $error("intc_sense: EXT_PIN outside the port");
      end
      if (PIN_W < 1) begin : g_bad_w
         $error("intc_sense: PIN_W must be at least 1");
      end
   endgenerate

   logic [PIN_W-1:0] prev_q;
   logic             primed_q;
   logic [PIN_W-1:0] chg;
   sense_e           mode;

   assign mode = sense_e'(ext_sense);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q   <= '0;
         primed_q <= 1'b0;
      end else begin
         prev_q   <= pin_lvl;
         primed_q <= 1'b1;
      end
   end

   assign chg      = (pin_lvl ^ prev_q) & {PIN_W{primed_q}};
   assign pchg_evt = |(chg & PC_PIN_EN);

   always_comb begin
      ext_evt = 1'b0;
      ext_lvl = 1'b0;
      unique case (mode)
         SENSE_LOW:  ext_lvl = ~pin_lvl[EXT_PIN];
         SENSE_ANY:  ext_evt = chg[EXT_PIN];
         SENSE_FALL: ext_evt = chg[EXT_PIN] & ~pin_lvl[EXT_PIN];
         SENSE_RISE: ext_evt = chg[EXT_PIN] &  pin_lvl[EXT_PIN];
         default:    ext_evt = 1'b0;
      endcase
   end

   // R6: in level mode no event is ever produced for the flag
   a_r6_level_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == SENSE_LOW) |-> !ext_evt);
endmodule

// File: rtl/intc_flag_bank.sv
module intc_flag_bank #(
   parameter int unsigned N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_evt,
   input  logic         wr_en,
   input  logic [N-1:0] wr_clr,
   input  logic [N-1:0] take_clr,
   output logic [N-1:0] flag_q
);
   generate
      if (N < 1) begin : g_bad_n
         $error("intc_flag_bank: N must be at least 1");
      end
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk) begin
            if (!rst_n)
               flag_q[i] <= 1'b0;
            else if (set_evt[i])
               flag_q[i] <= 1'b1;
            else if ((wr_en && wr_clr[i]) || take_clr[i])
               flag_q[i] <= 1'b0;
         end

         // R4: an event always leaves its flag set
         a_r4_flag_latched: assert property (@(posedge clk) disable iff (!rst_n)
            set_evt[i] |=> flag_q[i]);
         // R11: a flag with no event and no clear keeps its value
         a_r11_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_evt[i] && !(wr_en && wr_clr[i]) && !take_clr[i]) |=> $stable(flag_q[i]));
      end
   endgenerate
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
   parameter int unsigned N  = 5,
   parameter int unsigned VW = $clog2(N + 1)
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [VW-1:0] vec
);
   generate
      if ((1 << VW) < N + 1) begin : g_bad_vw
         $error("intc_prio_pick: VW too narrow for N");
      end
   endgenerate

   always_comb begin
      any = 1'b0;
      vec = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            vec = VW'(i + 1);
         end
      end
   end
endmodule

// File: rtl/intc_take_ctrl.sv
module intc_take_ctrl import intc_pkg::*; #(
   parameter int unsigned VW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          gie_q,
   input  logic          any,
   input  logic [VW-1:0] pick_vec,
   input  logic          ack,
   output logic          irq_req,
   output logic [VW-1:0] irq_vec,
   output logic          take
);
   take_st_e st_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= TK_IDLE;
         irq_vec <= '0;
      end else begin
         unique case (st_q)
            TK_IDLE: if (gie_q && any) begin
               st_q    <= TK_OFFER;
               irq_vec <= pick_vec;
            end
            TK_OFFER: if (ack) st_q <= TK_IDLE;
            default:  st_q <= TK_IDLE;
         endcase
      end
   end

   assign irq_req = (st_q == TK_OFFER);
   assign take    = irq_req & ack;

   // R12: offer and vector held until the acknowledge
   a_r12_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !ack) |=> (irq_req && $stable(irq_vec)));
   // R3: an offer only starts from an enabled state
   a_r3_gie_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> $past(gie_q));
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc import intc_pkg::*; #(
   parameter int unsigned PIN_W = 6,
   parameter int unsigned EXT_PIN = 1,
   parameter logic [PIN_W-1:0] PC_PIN_EN = {1'b0, {(PIN_W-1){1'b1}}}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PIN_W-1:0] pin_lvl,
   input  logic [1:0]       ext_sense,
   input  logic             tov_evt,
   input  logic             eerdy_evt,
   input  logic             cmp_evt,
   input  logic             flag_wr,
   input  logic [IRQ_N-1:0] flag_wdata,
   input  logic             mask_wr,
   input  logic [IRQ_N-1:0] mask_wdata,
   input  logic             gie_set,
   input  logic             gie_clr,
   input  logic             irq_ack,
   output logic             irq_req,
   output logic [VEC_W-1:0] irq_vec,
   output logic [IRQ_N-1:0] flags,
   output logic             gie
);
   logic             ext_evt, ext_lvl, pchg_evt;
   logic [IRQ_N-1:0] set_evt, take_clr, lvl_vec, pend;
   logic [IRQ_N-1:0] mask_q;
   logic             gie_q, any, take;
   logic [VEC_W-1:0] pick_vec;

   intc_sense #(.PIN_W(PIN_W), .EXT_PIN(EXT_PIN), .PC_PIN_EN(PC_PIN_EN)) u_sense (
      .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .ext_sense(ext_sense),
      .ext_evt(ext_evt), .ext_lvl(ext_lvl), .pchg_evt(pchg_evt));

   always_comb begin
      set_evt            = '0;
      set_evt[SRC_EXT]   = ext_evt;
      set_evt[SRC_PCHG]  = pchg_evt;
      set_evt[SRC_TOV]   = tov_evt;
      set_evt[SRC_EERDY] = eerdy_evt;
      set_evt[SRC_CMP]   = cmp_evt;
      lvl_vec            = '0;
      lvl_vec[SRC_EXT]   = ext_lvl;
   end

   generate
      for (genvar i = 0; i < IRQ_N; i++) begin : g_tclr
         assign take_clr[i] = take && (irq_vec == VEC_W'(i + 1));
      end
   endgenerate

   intc_flag_bank #(.N(IRQ_N)) u_flags (
      .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .wr_en(flag_wr),
      .wr_clr(flag_wdata), .take_clr(take_clr), .flag_q(flags));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
         gie_q  <= 1'b0;
      end else begin
         if (mask_wr) mask_q <= mask_wdata;
         if (take || gie_clr) gie_q <= 1'b0;
         else if (gie_set)    gie_q <= 1'b1;
      end
   end

   assign pend = (flags | lvl_vec) & mask_q;
   assign gie  = gie_q;

   intc_prio_pick #(.N(IRQ_N), .VW(VEC_W)) u_pick (
      .req(pend), .any(any), .vec(pick_vec));

   intc_take_ctrl #(.VW(VEC_W)) u_take (
      .clk(clk), .rst_n(rst_n), .gie_q(gie_q), .any(any), .pick_vec(pick_vec),
      .ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec), .take(take));

   logic [IRQ_N-1:0] below_m;
   always_comb begin
      below_m = '0;
      for (int i = 0; i < IRQ_N; i++)
         if (VEC_W'(i + 1) < irq_vec) below_m[i] = 1'b1;
   end

   // R2: no lower vector was pending when an offer started
   a_r2_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> (($past(pend) & below_m) == '0));
   // R2: offered vector always names a maskable slot
   a_r2_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_vec != '0 && irq_vec <= VEC_W'(IRQ_N)));
   // R10: taking an interrupt leaves the global enable cleared
   a_r10_take_clears_gie: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_ack) |=> !gie_q);
   // R5: an offered source was enabled when the offer began
   a_r5_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> ($past(mask_q) & ~below_m) != '0);
endmodule

// File: tb/prio_vec_intc_tb.sv
module prio_vec_intc_tb_top;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [5:0] pin_lvl;
   logic [1:0] ext_sense;
   logic       tov_evt, eerdy_evt, cmp_evt;
   logic       flag_wr, mask_wr, gie_set, gie_clr, irq_ack;
   logic [4:0] flag_wdata, mask_wdata;
   logic       irq_req, gie;
   logic [2:0] irq_vec;
   logic [4:0] flags;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   prio_vec_intc dut_i (
      .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .ext_sense(ext_sense),
      .tov_evt(tov_evt), .eerdy_evt(eerdy_evt), .cmp_evt(cmp_evt),
      .flag_wr(flag_wr), .flag_wdata(flag_wdata), .mask_wr(mask_wr),
      .mask_wdata(mask_wdata), .gie_set(gie_set), .gie_clr(gie_clr),
      .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec),
      .flags(flags), .gie(gie));

   task automatic chk(input string rq, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input int which);
      case (which)
         2: tov_evt = 1'b1;
         3: eerdy_evt = 1'b1;
         default: cmp_evt = 1'b1;
      endcase
      cyc(1);
      tov_evt = 1'b0; eerdy_evt = 1'b0; cmp_evt = 1'b0;
   endtask

   task automatic gie_on();
      gie_set = 1'b1; cyc(1); gie_set = 1'b0;
   endtask

   task automatic do_ack();
      irq_ack = 1'b1; cyc(1); irq_ack = 1'b0;
   endtask

   task automatic set_mask(input logic [4:0] m);
      mask_wdata = m; mask_wr = 1'b1; cyc(1); mask_wr = 1'b0;
   endtask

   task automatic clr_flags(input logic [4:0] m);
      flag_wdata = m; flag_wr = 1'b1; cyc(1); flag_wr = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 irq_req", irq_req, 0);
      chk("R1 flags", flags, 0);
      chk("R1 gie", gie, 0);
   endtask

   task automatic t_latch_disabled();
      set_mask(5'h1f);
      pulse(2);
      cyc(3);
      chk("R3 no req while gie=0", irq_req, 0);
      chk("R4 timer flag latched", flags, 5'b00100);
      gie_on(); cyc(1);
      chk("R4 req after gie", irq_req, 1);
      chk("R4 vector timer", irq_vec, 3);
      do_ack();
      chk("R10 req dropped", irq_req, 0);
      chk("R10 gie cleared", gie, 0);
      chk("R10 flag cleared", flags, 0);
   endtask

   task automatic t_priority();
      pulse(4); pulse(3); pulse(2);
      chk("R4 three flags", flags, 5'b11100);
      gie_on(); cyc(1);
      chk("R2 first vec", irq_vec, 3);
      do_ack(); gie_on(); cyc(1);
      chk("R2 second vec", irq_vec, 4);
      do_ack(); gie_on(); cyc(1);
      chk("R2 third vec", irq_vec, 5);
      do_ack();
      chk("R2 all served", flags, 0);
   endtask

   task automatic t_mask();
      set_mask(5'b01111);
      pulse(4);
      gie_on(); cyc(3);
      chk("R5 masked no req", irq_req, 0);
      chk("R5 flag still set", flags, 5'b10000);
      set_mask(5'h1f); cyc(1);
      chk("R5 req once enabled", irq_req, 1);
      cyc(5);
      chk("R12 req held", irq_req, 1);
      chk("R12 vec held", irq_vec, 5);
      irq_ack = 1'b1; gie_set = 1'b1; cyc(1); irq_ack = 1'b0; gie_set = 1'b0;
      chk("R10 ack beats gie_set", gie, 0);
      chk("R10 cmp flag cleared", flags, 0);
   endtask

   task automatic t_w1c();
      pulse(2); pulse(3);
      clr_flags(5'b00000); cyc(1);
      chk("R11 zero write keeps", flags, 5'b01100);
      clr_flags(5'b00100); cyc(1);
      chk("R11 one clears bit", flags, 5'b01000);
      clr_flags(5'b01000); cyc(1);
      chk("R11 last cleared", flags, 0);
   endtask

   task automatic t_pchg();
      pin_lvl[3] = 1'b1; cyc(2);
      chk("R8 enabled pin change", flags, 5'b00010);
      clr_flags(5'b00010); cyc(1);
      pin_lvl[5] = 1'b1; cyc(2);
      chk("R8 excluded pin ignored", flags, 0);
      pin_lvl[5] = 1'b0; pin_lvl[3] = 1'b0; cyc(2);
      clr_flags(5'h1f); cyc(1);
   endtask

   task automatic t_edges();
      ext_sense = 2'd3; cyc(1);
      pin_lvl[1] = 1'b0; cyc(2);
      chk("R7 rise mode ignores fall", flags, 5'b00010);
      pin_lvl[1] = 1'b1; cyc(2);
      chk("R7 rise mode flags rise", flags, 5'b00011);
      clr_flags(5'h1f);
      ext_sense = 2'd2; cyc(1);
      pin_lvl[1] = 1'b0; cyc(2);
      chk("R9 both flags on fall", flags, 5'b00011);
      gie_on(); cyc(1);
      chk("R9 ext first", irq_vec, 1);
      do_ack(); gie_on(); cyc(1);
      chk("R9 pin change next", irq_vec, 2);
      do_ack();
      ext_sense = 2'd1; cyc(1);
      pin_lvl[1] = 1'b1; cyc(2);
      chk("R7 any-edge mode", flags[0], 1);
      clr_flags(5'h1f); cyc(1);
   endtask

   task automatic t_level();
      ext_sense = 2'd0;
      set_mask(5'b00001);
      gie_on(); cyc(2);
      chk("R6 pin high no req", irq_req, 0);
      pin_lvl[1] = 1'b0; cyc(2);
      chk("R6 pin low req", irq_req, 1);
      chk("R6 vec ext", irq_vec, 1);
      chk("R6 no ext flag", flags[0], 0);
      do_ack();
      pin_lvl[1] = 1'b1; cyc(1);
      gie_on(); cyc(3);
      chk("R6 released no req", irq_req, 0);
      gie_clr = 1'b1; cyc(1); gie_clr = 1'b0;
      clr_flags(5'h1f); cyc(1);
   endtask

   initial begin
      rst_n = 1'b0; pin_lvl = 6'b000010; ext_sense = 2'd2;
      tov_evt = 0; eerdy_evt = 0; cmp_evt = 0;
      flag_wr = 0; mask_wr = 0; gie_set = 0; gie_clr = 0; irq_ack = 0;
      flag_wdata = '0; mask_wdata = '0;
      cyc(3); rst_n = 1'b1; cyc(1);
      t_reset();
      t_latch_disabled();
      t_priority();
      t_mask();
      t_w1c();
      t_pchg();
      t_edges();
      t_level();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule